// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Mode Controller

This block holds the operating mode of a CAN receive acceptance filter and protects the configuration of its identifier table. A processor reaches it over an APB-style register port. One register selects the mode: filter off, filter bypassed, or normal screening with an optional FullCAN enhancement. Five 10-bit boundary registers split a 512-word, 32-bit identifier table into sections. The block drives three things: the effective mode, a halt signal that holds the filter's search state machine in reset, and a per-frame accept decision.

The table search, FullCAN storage and the CAN controllers are outside this block. They reach it only as a frame-valid strobe and a match result. The boundary registers can be written only while the filter is off or bypassed, so software cannot move the table sections while a search may be running. Writes at other times are dropped without any indication.

Top module: `canaf_mode_ctrl`

## Requirements
- R1: After reset the mode register reads 0x0000_0001 (off set, bypass clear, FullCAN clear), every section register reads 0, `accept` is 0, `fsm_halt` is 1 and `eff_mode` is off.
- R2: The mode register is at byte offset 0x00. Bit 0 is off, bit 1 is bypass and bit 2 is the FullCAN enable. Bits 31:3 ignore writes and read as 0.
- R3: `eff_mode` encodes 2'b00 = off, 2'b01 = bypass and 2'b10 = normal. Bypass set gives bypass whatever the off bit is. Off set with bypass clear gives off. Both clear gives normal.
- R4: `fsm_halt` is 1 exactly when the off bit or the bypass bit is set.
- R5: With off set and bypass clear, no frame is accepted, whatever the value of `id_match`.
- R6: With bypass set, every frame is accepted, whatever the values of the off bit and `id_match`.
- R7: With off and bypass both clear, a frame is accepted only when `id_match` is 1 in the strobe cycle.
- R8: `accept` is a registered result. It is 1 for one cycle, the cycle after a `frame_vld` cycle, and is decided by the mode bits held before that clock edge. A mode write on the same edge does not affect it. Without a strobe, `accept` is 0.
- R9: `fullcan_en` equals mode bit 2 while the mode is normal, and is 0 in off and bypass modes.
- R10: The five section registers sit at byte offsets 0x04, 0x08, 0x0C, 0x10 and 0x14. A write stores only data bits 9:0, and bits 31:10 read as 0.
- R11: A section register write takes effect only if, before that clock edge, the off bit or the bypass bit is set. Otherwise the write is discarded and the register keeps its value.
- R12: Reads of every register return its contents in every mode. Word offsets above 0x14 read as 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a register transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid combinationally while psel is 1 |
| frame_vld | input | 1 | One-cycle strobe per received frame |
| id_match | input | 1 | Table search hit for the strobed frame |
| eff_mode | output | 2 | Effective mode (see R3) |
| fsm_halt | output | 1 | Holds the search state machine in reset |
| fullcan_en | output | 1 | FullCAN enhancement active |
| accept | output | 1 | Accept decision, one cycle after the strobe |

## Verification
Register writes take effect at the clock edge that ends the access phase. The bench therefore checks `eff_mode`, `fsm_halt`, `fullcan_en` and read-back values at the next falling edge. Reads are combinational and are sampled shortly after `psel` and `paddr` are driven. `accept` is due one clock edge after the strobe, so the bench computes the expected value from its model state as it was before that edge and samples at the following falling edge. One directed case puts a mode write and a frame strobe on the same edge to confirm the decision uses the old mode bits.

// File: rtl/canaf_pkg.sv
package canaf_pkg;

   typedef enum logic [1:0] {
      AF_OFF    = 2'b00,
      AF_BYPASS = 2'b01,
      AF_NORMAL = 2'b10
   } af_mode_e;

   localparam int MODE_BIT_OFF = 0;
   localparam int MODE_BIT_BYP = 1;
   localparam int MODE_BIT_FC  = 2;
   localparam int MODE_BITS    = 3;

endpackage

// File: rtl/canaf_mode_reg.sv
module canaf_mode_reg
   import canaf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic              off_o,
   output logic              byp_o,
   output af_mode_e          mode_o,
   output logic              halt_o,
   output logic              fullcan_o,
   output logic [DATA_W-1:0] rdata_o
);

   if (DATA_W < MODE_BITS) begin : g_bad_width
      $error("canaf_mode_reg: DATA_W too small for mode bits");
   end

   logic off_q, byp_q, fc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= 1'b1;
         byp_q <= 1'b0;
         fc_q  <= 1'b0;
      end else if (wr_en) begin
         off_q <= wdata[MODE_BIT_OFF];
         byp_q <= wdata[MODE_BIT_BYP];
         fc_q  <= wdata[MODE_BIT_FC];
      end
   end

   always_comb begin
      if (byp_q)      mode_o = AF_BYPASS;
      else if (off_q) mode_o = AF_OFF;
      else            mode_o = AF_NORMAL;
   end

   assign off_o     = off_q;
   assign byp_o     = byp_q;
   assign halt_o    = off_q | byp_q;
   assign fullcan_o = fc_q & (mode_o == AF_NORMAL);

   always_comb begin
      rdata_o               = '0;
      rdata_o[MODE_BIT_OFF] = off_q;
      rdata_o[MODE_BIT_BYP] = byp_q;
      rdata_o[MODE_BIT_FC]  = fc_q;
   end

   // R4
   halt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o == (mode_o != AF_NORMAL));

   // R9
   fullcan_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fullcan_o |-> (mode_o == AF_NORMAL));

   // R3
   bypass_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byp_q |-> (mode_o == AF_BYPASS));

endmodule

// File: rtl/canaf_sect_regs.sv
module canaf_sect_regs #(
   parameter int DATA_W   = 32,
   parameter int SECT_W   = 10,
   parameter int NUM_SECT = 5,
   parameter int SIDX_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              allow,
   input  logic [SIDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SIDX_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rdata_o
);

   if (SECT_W > DATA_W) begin : g_bad_sect
      $error("canaf_sect_regs: SECT_W exceeds DATA_W");
   end
   if (NUM_SECT < 1) begin : g_bad_num
      $error("canaf_sect_regs: NUM_SECT must be at least 1");
   end

   logic [SECT_W-1:0] sect_q [NUM_SECT];

   for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
      logic hit;
      assign hit = wr_en && allow && (wr_idx == SIDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   sect_q[i] <= '0;
         else if (hit) sect_q[i] <= wdata[SECT_W-1:0];
      end

      // R11
      sect_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !allow && wr_idx == SIDX_W'(i)) |=> $stable(sect_q[i]));

      // R10
      sect_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_en || wr_idx != SIDX_W'(i)) |=> $stable(sect_q[i]));
   end

   always_comb begin
      rdata_o = '0;
      for (int k = 0; k < NUM_SECT; k++) begin
         if (rd_idx == SIDX_W'(k)) rdata_o = DATA_W'(sect_q[k]);
      end
   end

endmodule

// File: rtl/canaf_accept.sv
module canaf_accept (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_vld,
   input  logic id_match,
   input  logic off_i,
   input  logic byp_i,
   output logic accept_o
);

   logic decide;
   assign decide = frame_vld & (byp_i | (~off_i & id_match));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) accept_o <= 1'b0;
      else        accept_o <= decide;
   end

   // R5
   off_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && off_i && !byp_i) |=> !accept_o);

   // R6
   bypass_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && byp_i) |=> accept_o);

   // R7
   normal_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && !off_i && !byp_i) |=> (accept_o == $past(id_match)));

   // R8
   no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_vld |=> !accept_o);

endmodule

// File: rtl/canaf_mode_ctrl.sv
module canaf_mode_ctrl
   import canaf_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int SECT_W   = 10,
   parameter int NUM_SECT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic              frame_vld,
   input  logic              id_match,
   output logic [1:0]        eff_mode,
   output logic              fsm_halt,
   output logic              fullcan_en,
   output logic              accept
);

   localparam int WORD_W = ADDR_W - 2;
   localparam int SIDX_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("canaf_mode_ctrl: ADDR_W too small");
   end
   if (NUM_SECT + 1 > (1 << WORD_W)) begin : g_bad_map
      $error("canaf_mode_ctrl: address space cannot hold all registers");
   end

   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] sect_off;
   logic              mode_hit, sect_hit, wr_cycle;
   logic              off_b, byp_b;
   af_mode_e          mode_e;
   logic [DATA_W-1:0] mode_rd, sect_rd;

   assign word     = paddr[ADDR_W-1:2];
   assign sect_off = word - WORD_W'(1);
   assign mode_hit = (word == '0);
   assign sect_hit = (word >= WORD_W'(1)) && (word <= WORD_W'(NUM_SECT));
   assign wr_cycle = psel & penable & pwrite;

   canaf_mode_reg #(.DATA_W(DATA_W)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_cycle & mode_hit),
      .wdata     (pwdata),
      .off_o     (off_b),
      .byp_o     (byp_b),
      .mode_o    (mode_e),
      .halt_o    (fsm_halt),
      .fullcan_o (fullcan_en),
      .rdata_o   (mode_rd)
   );

   canaf_sect_regs #(
      .DATA_W   (DATA_W),
      .SECT_W   (SECT_W),
      .NUM_SECT (NUM_SECT),
      .SIDX_W   (SIDX_W)
   ) u_sect (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_cycle & sect_hit),
      .allow   (off_b | byp_b),
      .wr_idx  (sect_off[SIDX_W-1:0]),
      .wdata   (pwdata),
      .rd_idx  (sect_off[SIDX_W-1:0]),
      .rdata_o (sect_rd)
   );

   canaf_accept u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_vld (frame_vld),
      .id_match  (id_match),
      .off_i     (off_b),
      .byp_i     (byp_b),
      .accept_o  (accept)
   );

   assign eff_mode = mode_e;

   always_comb begin
      if (!psel)         prdata = '0;
      else if (mode_hit) prdata = mode_rd;
      else if (sect_hit) prdata = sect_rd;
      else               prdata = '0;
   end

   // R2
   mode_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && mode_hit) |-> (prdata[DATA_W-1:MODE_BITS] == '0));

   // R12
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !mode_hit && !sect_hit) |-> (prdata == '0));

endmodule

// File: tb/canaf_mode_ctrl_tb_top.sv
module canaf_mode_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        frame_vld = 1'b0, id_match = 1'b0;
   logic [1:0]  eff_mode;
   logic        fsm_halt, fullcan_en, accept;

   int nvec = 0;
   int nerr = 0;

   // model state
   logic       m_off = 1'b1, m_byp = 1'b0, m_fc = 1'b0;
   logic [9:0] m_sect [5];

   always #4 clk = ~clk;

   canaf_mode_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .frame_vld(frame_vld), .id_match(id_match), .eff_mode(eff_mode),
      .fsm_halt(fsm_halt), .fullcan_en(fullcan_en), .accept(accept)
   );

   function automatic logic [1:0] exp_mode();
      if (m_byp)      return 2'b01;
      else if (m_off) return 2'b00;
      else            return 2'b10;
   endfunction

   function automatic logic exp_accept(logic fv, logic mt);
      return fv & (m_byp | (~m_off & mt));
   endfunction

   function automatic logic [31:0] exp_read(logic [7:0] a);
      int idx = int'(a[7:2]);
      if (idx == 0)               return {29'b0, m_fc, m_byp, m_off};
      else if (idx >= 1 && idx <= 5) return {22'b0, m_sect[idx-1]};
      else                        return 32'b0;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic chk_status();
      chk("R3 eff_mode", {30'b0, eff_mode}, {30'b0, exp_mode()});
      chk("R4 fsm_halt", {31'b0, fsm_halt}, {31'b0, m_off | m_byp});
      chk("R9 fullcan_en", {31'b0, fullcan_en},
          {31'b0, m_fc & ~m_off & ~m_byp});
   endtask

   task automatic model_write(logic [7:0] a, logic [31:0] d);
      int idx = int'(a[7:2]);
      if (idx == 0) begin
         m_off = d[0]; m_byp = d[1]; m_fc = d[2];
      end else if (idx >= 1 && idx <= 5 && (m_off || m_byp)) begin
         m_sect[idx-1] = d[9:0];
      end
   endtask

   // two-phase write; optional frame strobe on the access cycle
   task automatic apb_write(logic [7:0] a, logic [31:0] d, logic fv, logic mt,
                            string req);
      logic ea;
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1; frame_vld = fv; id_match = mt;
      ea = exp_accept(fv, mt);
      model_write(a, d);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0; frame_vld = 1'b0;
      #1;
      chk(req, {31'b0, accept}, {31'b0, ea});
      chk_status();
   endtask

   task automatic apb_read(logic [7:0] a, string req);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      #1;
      chk(req, prdata, exp_read(a));
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic frame(logic fv, logic mt, string req);
      logic ea;
      @(negedge clk);
      frame_vld = fv; id_match = mt;
      ea = exp_accept(fv, mt);
      @(negedge clk);
      frame_vld = 1'b0; id_match = 1'b0;
      #1;
      chk(req, {31'b0, accept}, {31'b0, ea});
   endtask

   initial begin
      #(8 * 150000);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 5; i++) m_sect[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;

      // R1 reset state
      chk("R1 accept", {31'b0, accept}, 32'd0);
      chk("R1 fsm_halt", {31'b0, fsm_halt}, 32'd1);
      chk("R1 eff_mode", {30'b0, eff_mode}, 32'd0);
      apb_read(8'h00, "R1 mode reset");
      for (int i = 1; i <= 5; i++) apb_read(8'(i * 4), "R1 section reset");

      // R5 off mode rejects, even with match
      frame(1'b1, 1'b1, "R5 off with match");
      frame(1'b1, 1'b0, "R5 off no match");

      // R10 write in off mode, upper bits dropped
      apb_write(8'h04, 32'hFFFF_F2A5, 1'b0, 1'b0, "R10 write accept");
      apb_read(8'h04, "R10 upper bits read zero");
      apb_write(8'h14, 32'h0000_03FF, 1'b0, 1'b0, "R10 last section");
      apb_read(8'h14, "R10 last section read");

      // R6 bypass with off also set, no match
      apb_write(8'h00, 32'h3, 1'b0, 1'b0, "R3 enter bypass");
      frame(1'b1, 1'b0, "R6 bypass no match");
      apb_write(8'h00, 32'h2, 1'b0, 1'b0, "R3 bypass only");
      frame(1'b1, 1'b0, "R6 bypass off clear");
      apb_write(8'h08, 32'h0000_0123, 1'b0, 1'b0, "R11 bypass write");
      apb_read(8'h08, "R11 bypass write stored");

      // normal with FullCAN; reserved bits set in write data
      apb_write(8'h00, 32'hFFFF_FFFC, 1'b0, 1'b0, "R9 normal fullcan");
      apb_read(8'h00, "R2 reserved bits zero");
      frame(1'b1, 1'b1, "R7 normal match");
      frame(1'b1, 1'b0, "R7 normal miss");
      frame(1'b0, 1'b1, "R8 no strobe");

      // R11 blocked write in normal, R12 read in normal
      apb_write(8'h0C, 32'h0000_0155, 1'b0, 1'b0, "R11 normal write");
      apb_read(8'h0C, "R11 normal write discarded");
      apb_read(8'h04, "R12 read in normal");

      // R8 mode write on the same edge as a strobe: old mode decides
      apb_write(8'h00, 32'h2, 1'b1, 1'b0, "R8 old mode normal miss");
      frame(1'b1, 1'b0, "R8 new mode bypass");
      apb_write(8'h00, 32'h1, 1'b1, 1'b0, "R8 old mode bypass");

      // R12 unmapped
      apb_write(8'h1C, 32'hDEAD_BEEF, 1'b0, 1'b0, "R12 unmapped write");
      apb_read(8'h1C, "R12 unmapped read");
      for (int i = 0; i <= 5; i++) apb_read(8'(i * 4), "R12 map unchanged");

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         int op = int'($urandom_range(0, 5));
         logic [7:0] a = 8'($urandom_range(0, 8) * 4);
         logic [31:0] d = $urandom;
         case (op)
            0: apb_write(8'h00, d, 1'($urandom_range(0, 1)),
                         1'($urandom_range(0, 1)), "R8 random mode write");
            1, 2: apb_write(a, d, 1'($urandom_range(0, 1)),
                            1'($urandom_range(0, 1)), "R11 random write");
            3: apb_read(a, "R12 random read");
            default: frame(1'($urandom_range(0, 3) != 0),
                           1'($urandom_range(0, 1)), "R7 random frame");
         endcase
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule